// File: doc/BRIEF.md
# Raw NAND Flash Controller with Byte-Stream ECC

This block connects a 32-bit register bus to an 8-bit raw NAND flash device. Software reaches it through a small set of byte offsets. It writes a command byte or an address byte, and the block drives the matching latch cycle on the flash pins. It writes or reads the data offset to move one byte to or from the flash. It reads a status offset to see the flash ready/busy line.

Every data byte that crosses the pins while the block is enabled is folded into a running parity accumulator. The accumulator holds line parity, taken over the position of the byte in the stream, and column parity, taken over the bit positions inside each byte. Software reads the result as three inverted bytes at consecutive offsets and compares it with the code stored in the page's spare area.

The register bus is a single valid/ready channel. The master raises `bus_valid` with `bus_write`, `bus_addr` and `bus_wdata`, and must hold all of them stable until it sees `bus_ready`. `bus_ready` is high for exactly one cycle. In that cycle `bus_rdata` carries the read result, and the master drops `bus_valid`. The block applies back-pressure simply by delaying `bus_ready` while a flash pin cycle is in progress. The write-protect input and the flash pins are plain levels.

Top module: `nand_ecc_ctrl`

## Requirements
- R1: After reset the configuration, command and address offsets read 0. All three ECC bytes read 0xFF. The pins are idle: CLE and ALE low, nCE, nWE and nRE high, and the I/O bus not driven.
- R2: A write to offset 0x00 stores the written bits under mask 0x9FFF, except bit 12, which always reads back 0. A written value with bit 12 set also clears the ECC accumulator, so the three ECC bytes read 0xFF afterwards.
- R3: While configuration bit 15 (enable) is 0, writes to 0x04, 0x08 and 0x0C produce no strobe on the pins and leave the ECC unchanged, and a read of 0x0C returns 0. The command and address registers still store the written byte.
- R4: A write to 0x04 with the block enabled stores bits 7:0 and reads back that byte. It then drives a pin cycle with CLE high, ALE low, the byte on the I/O bus and nCE at the level of configuration bit 11.
- R5: A write to 0x08 with the block enabled stores bits 7:0 and reads back that byte. It drives the same pin cycle as R4, but with ALE high and CLE low.
- R6: A write to 0x0C with the block enabled drives bits 7:0 onto the I/O bus with one nWE strobe, CLE and ALE low, and folds the byte into the ECC.
- R7: A read of 0x0C with the block enabled gives one nRE strobe with the I/O bus released. It returns the byte present on the flash I/O input, in bits 7:0 with the upper bits 0, and folds that byte into the ECC.
- R8: A read of 0x10 returns the flash ready/busy input in bit 0 and 0 in all other bits.
- R9: The accumulator keeps 9 line-parity pairs and 6 column parities. Line pair n (n = 0..7) toggles its high half when a byte of odd bit parity has stream position bit n set, and its low half otherwise. Pair 8 only ever toggles its low half. Column parity j toggles by the XOR of those data bits b whose bit (j/2) equals (j mod 2). The code word places pair n's high half at bit 2n, its low half at bit 2n+1, and column j at bit 18+j. The word is inverted, and offsets 0x14, 0x15 and 0x16 return its bits 7:0, 15:8 and 23:16.
- R10: A request is accepted on a rising edge where the block is idle and `bus_valid` is high. A register-only access raises `bus_ready` in the next cycle. A pin access instead drives one setup cycle, then one cycle with the strobe (nWE or nRE) low, then one cycle with `bus_ready` high and the pins idle. `bus_ready` lasts one cycle, and one idle cycle follows it before the next acceptance.
- R11: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x15 and 0x16 return 0. Writes to them change no register and drive no pins.
- R12: The nWP pin is the inverse of the `wp_on` input at all times.
- R13: The stream position used for line parity is 8 bits wide and wraps, so the 257th byte after a clear is weighted as position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid, held until bus_ready |
| bus_ready | output | 1 | One-cycle completion of the request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| wp_on | input | 1 | Write protect active (high) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nce | output | 1 | Chip enable, active low |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_nwp | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte returned by the flash |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions watch cycle-level pin rules on every clock: CLE and ALE are never high together, nWE and nRE are never low together, each strobe lasts a single clock, and no strobe occurs while the enable bit is clear. They also check that `bus_ready` is a single-cycle pulse and that a clear request empties the accumulator. Only the bench scenarios can show that the values are right. Those values are the latched bytes on the I/O bus, the readback masking of the configuration, the exact interleaved and inverted ECC bytes after mixed write and read streams, and the position wrap after 256 bytes, all compared against a behavioural parity model.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 16;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ADR  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_DAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STS  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_ECC0 = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_ECC1 = 5'h15;
  localparam logic [ADDR_W-1:0] OFF_ECC2 = 5'h16;

  // stored configuration bits (the clear-request bit is not kept)
  localparam int              CLR_BIT  = 12;
  localparam int              EN_BIT   = 15;
  localparam int              CE_BIT   = 11;
  localparam logic [CFG_W-1:0] CFG_KEEP = 16'h9FFF & ~(16'h1 << CLR_BIT);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    PK_NONE,
    PK_CMD,
    PK_ADR,
    PK_DAT
  } pin_kind_t;

  // data bits that feed column parity j: bit b is used when bit (j/2) of b equals j%2
  function automatic logic [BYTE_W-1:0] col_mask(input int j);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) begin
      m[b] = (((b >> (j / 2)) & 1) == (j % 2));
    end
    return m;
  endfunction

endpackage

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_cmd,
  input  logic              wr_adr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] adr_q,
  output logic              ecc_clr
);

  assign ecc_clr = wr_cfg && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmd_q <= '0;
      adr_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= wdata & CFG_KEEP;
      if (wr_cmd) cmd_q <= wdata[BYTE_W-1:0];
      if (wr_adr) adr_q <= wdata[BYTE_W-1:0];
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q)) else $error("command register moved without a write"); // R4

  AST_ADR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_adr |=> $stable(adr_q)) else $error("address register moved without a write"); // R5

endmodule

// File: rtl/nfc_ecc.sv
module nfc_ecc
  import nfc_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int LP_PAIRS = 9,
  parameter int COL_W    = 6,
  localparam int ECC_W   = 2 * LP_PAIRS + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fold,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ECC_W-1:0]  ecc_word
);

  logic [IDX_W-1:0]    idx_q;
  logic [LP_PAIRS-1:0] hi_v, lo_v;
  logic [COL_W-1:0]    col_v;
  logic [ECC_W-1:0]    raw;
  logic                odd_byte;

  assign odd_byte = ^byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx_q <= '0;
    else if (fold)     idx_q <= idx_q + 1'b1;
  end

  for (genvar n = 0; n < LP_PAIRS; n++) begin : g_pair
    logic sel;
    logic hi_q, lo_q;
    if (n < IDX_W) begin : g_idx
      assign sel = idx_q[n];
    end else begin : g_pad
      assign sel = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else if (fold && odd_byte) begin
        if (sel) hi_q <= ~hi_q;
        else     lo_q <= ~lo_q;
      end
    end
    assign hi_v[n]       = hi_q;
    assign lo_v[n]       = lo_q;
    assign raw[2*n]      = hi_q;
    assign raw[2*n + 1]  = lo_q;
  end

  for (genvar j = 0; j < COL_W; j++) begin : g_col
    localparam logic [BYTE_W-1:0] MASK = col_mask(j);
    logic c_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) c_q <= 1'b0;
      else if (fold)     c_q <= c_q ^ (^(byte_in & MASK));
    end
    assign col_v[j]              = c_q;
    assign raw[2*LP_PAIRS + j]   = c_q;
  end

  assign ecc_word = ~raw;

  AST_ECC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hi_v == '0 && lo_v == '0 && col_v == '0)) else $error("clear left parity set"); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && !clr) |=> idx_q == $past(idx_q) + 1'b1) else $error("position did not advance"); // R13

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_reg,
  input  logic              start_pin,
  input  pin_kind_t         kind,
  input  logic              is_read,
  input  logic [BYTE_W-1:0] byte_out,
  input  logic              nce_level,
  input  logic [BYTE_W-1:0] io_in,
  output phase_t            phase,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              fold,
  output logic [BYTE_W-1:0] fold_byte,
  output logic              cle,
  output logic              ale,
  output logic              nce,
  output logic              nwe,
  output logic              nre,
  output logic [BYTE_W-1:0] io_out,
  output logic              io_oe
);

  pin_kind_t         kind_q;
  logic              rd_q;
  logic [BYTE_W-1:0] byte_q;
  logic              nce_q;
  logic              active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind_q  <= PK_NONE;
      rd_q    <= 1'b0;
      byte_q  <= '0;
      nce_q   <= 1'b1;
      rd_byte <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_pin) begin
            kind_q <= kind;
            rd_q   <= is_read;
            byte_q <= byte_out;
            nce_q  <= nce_level;
            phase  <= PH_SETUP;
          end else if (start_reg) begin
            phase  <= PH_DONE;
          end
        end
        PH_SETUP:  phase <= PH_STROBE;
        PH_STROBE: begin
          if (rd_q) rd_byte <= io_in;
          phase <= PH_DONE;
        end
        PH_DONE:   phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  assign active    = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign cle       = active && (kind_q == PK_CMD);
  assign ale       = active && (kind_q == PK_ADR);
  assign nce       = active ? nce_q : 1'b1;
  assign io_oe     = active && !rd_q;
  assign io_out    = byte_q;
  assign nwe       = !((phase == PH_STROBE) && !rd_q);
  assign nre       = !((phase == PH_STROBE) && rd_q);
  assign fold      = (phase == PH_STROBE) && (kind_q == PK_DAT);
  assign fold_byte = rd_q ? io_in : byte_q;

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)) else $error("both latch enables high"); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nwe && !nre)) else $error("both strobes low"); // R10

  AST_WE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !nwe |=> nwe) else $error("write strobe longer than one clock"); // R6

  AST_RE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !nre |=> nre) else $error("read strobe longer than one clock"); // R7

  AST_RE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !nre |-> !io_oe) else $error("bus driven during read"); // R7

endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_on,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_nce,
  output logic              nand_nwe,
  output logic              nand_nre,
  output logic              nand_nwp,
  output logic [BYTE_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [BYTE_W-1:0] nand_io_in,
  input  logic              nand_rb
);

  localparam int ECC_W = 24;

  phase_t            phase;
  logic [CFG_W-1:0]  cfg_q;
  logic [BYTE_W-1:0] cmd_q, adr_q, rd_byte, fold_byte;
  logic [ECC_W-1:0]  ecc_word;
  logic              ecc_clr, fold;
  logic              accept, enabled, pin_op, reg_op;
  logic              wr_cfg, wr_cmd, wr_adr;
  pin_kind_t         kind;
  logic [DATA_W-1:0] reg_rdata, rdata_q;
  logic              dat_rd_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

  assign accept  = (phase == PH_IDLE) && bus_valid;
  assign enabled = cfg_q[EN_BIT];
  assign wr_cfg  = accept && bus_write && (bus_addr == OFF_CFG);
  assign wr_cmd  = accept && bus_write && (bus_addr == OFF_CMD);
  assign wr_adr  = accept && bus_write && (bus_addr == OFF_ADR);

  always_comb begin
    kind = PK_NONE;
    if (bus_write) begin
      if (bus_addr == OFF_CMD)      kind = PK_CMD;
      else if (bus_addr == OFF_ADR) kind = PK_ADR;
      else if (bus_addr == OFF_DAT) kind = PK_DAT;
    end else if (bus_addr == OFF_DAT) begin
      kind = PK_DAT;
    end
  end

  assign pin_op = accept && enabled && (kind != PK_NONE);
  assign reg_op = accept && !pin_op;

  always_comb begin
    reg_rdata = '0;
    unique case (bus_addr)
      OFF_CFG:  reg_rdata[CFG_W-1:0]  = cfg_q;
      OFF_CMD:  reg_rdata[BYTE_W-1:0] = cmd_q;
      OFF_ADR:  reg_rdata[BYTE_W-1:0] = adr_q;
      OFF_STS:  reg_rdata[0]          = nand_rb;
      OFF_ECC0: reg_rdata[BYTE_W-1:0] = ecc_word[7:0];
      OFF_ECC1: reg_rdata[BYTE_W-1:0] = ecc_word[15:8];
      OFF_ECC2: reg_rdata[BYTE_W-1:0] = ecc_word[23:16];
      default:  reg_rdata             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      dat_rd_q <= 1'b0;
    end else if (accept) begin
      rdata_q  <= bus_write ? '0 : reg_rdata;
      dat_rd_q <= pin_op && !bus_write;
    end
  end

  assign bus_ready = (phase == PH_DONE);
  assign bus_rdata = !bus_ready ? '0 :
                     dat_rd_q   ? {{(DATA_W-BYTE_W){1'b0}}, rd_byte} : rdata_q;
  assign nand_nwp  = !wp_on;

  nfc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cfg  (wr_cfg),
    .wr_cmd  (wr_cmd),
    .wr_adr  (wr_adr),
    .wdata   (bus_wdata[CFG_W-1:0]),
    .cfg_q   (cfg_q),
    .cmd_q   (cmd_q),
    .adr_q   (adr_q),
    .ecc_clr (ecc_clr)
  );

  nfc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_reg (reg_op),
    .start_pin (pin_op),
    .kind      (kind),
    .is_read   (!bus_write),
    .byte_out  (bus_wdata[BYTE_W-1:0]),
    .nce_level (cfg_q[CE_BIT]),
    .io_in     (nand_io_in),
    .phase     (phase),
    .rd_byte   (rd_byte),
    .fold      (fold),
    .fold_byte (fold_byte),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .nce       (nand_nce),
    .nwe       (nand_nwe),
    .nre       (nand_nre),
    .io_out    (nand_io_out),
    .io_oe     (nand_io_oe)
  );

  nfc_ecc #(
    .IDX_W    (8),
    .LP_PAIRS (9),
    .COL_W    (6)
  ) u_ecc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ecc_clr),
    .fold     (fold),
    .byte_in  (fold_byte),
    .ecc_word (ecc_word)
  );

  AST_NO_PIN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_nwe) || $fell(nand_nre) |-> enabled) else $error("strobe while disabled"); // R3

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready) else $error("ready held for more than a cycle"); // R10

  AST_WP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    nand_nwp != wp_on) else $error("write protect pin wrong"); // R12

endmodule

// File: tb/nand_ecc_ctrl_tb.sv
module nand_ecc_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        wp_on = 1'b1;
  logic        nand_cle, nand_ale, nand_nce, nand_nwe, nand_nre, nand_nwp, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in = 8'h00;
  logic        nand_rb = 1'b1;

  int tests = 0, fails = 0;
  bit busy = 1'b1;
  logic [15:0] m_cfg = 16'h0;
  logic [7:0]  ecc_q[$];
  logic [7:0]  sent_q[$];

  always #4 clk = ~clk;

  nand_ecc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wp_on(wp_on), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_nce(nand_nce), .nand_nwe(nand_nwe), .nand_nre(nand_nre), .nand_nwp(nand_nwp),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit pins_idle();
    return !nand_cle && !nand_ale && nand_nce && nand_nwe && nand_nre && !nand_io_oe;
  endfunction

  // behavioural parity model over the byte stream since the last clear
  function automatic logic [23:0] ecc_model();
    logic [23:0] w = '0;
    int hi[9], lo[9], cp[6];
    foreach (hi[n]) begin hi[n] = 0; lo[n] = 0; end
    foreach (cp[j]) cp[j] = 0;
    foreach (ecc_q[i]) begin
      logic [7:0] b = ecc_q[i];
      int pos = i % 256;
      if (^b) begin
        for (int n = 0; n < 9; n++) begin
          if (n < 8 && ((pos >> n) & 1) == 1) hi[n] ^= 1;
          else lo[n] ^= 1;
        end
      end
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 8; k++)
          if (((k >> (j / 2)) & 1) == (j % 2)) cp[j] ^= int'(b[k]);
    end
    for (int n = 0; n < 9; n++) begin
      w[2*n]   = hi[n][0];
      w[2*n+1] = lo[n][0];
    end
    for (int j = 0; j < 6; j++) w[18+j] = cp[j][0];
    return ~w;
  endfunction

  // per-clock idle comparison outside transactions
  always @(negedge clk) begin
    if (!busy) begin
      chk(pins_idle() && !bus_ready, "R1 idle pins", {nand_cle, nand_ale, nand_nce, nand_nwe, nand_nre, nand_io_oe, bus_ready}, 7'b0011100);
      chk(nand_nwp == !wp_on, "R12 write protect", nand_nwp, !wp_on);
    end
  end

  task automatic acc(input bit wr, input logic [4:0] a, input logic [31:0] d,
                     output logic [31:0] q, input string tag);
    bit en = m_cfg[15];
    bit is_pin = en && (wr ? (a == 5'h04 || a == 5'h08 || a == 5'h0C) : (a == 5'h0C));
    int last = is_pin ? 3 : 1;
    busy = 1'b1;
    q = '0;
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k < last) begin
        chk(!bus_ready, {tag, " R10 early ready"}, bus_ready, 0);
        chk(nand_cle == (wr && a == 5'h04), {tag, " R4 cle"}, nand_cle, (wr && a == 5'h04));
        chk(nand_ale == (wr && a == 5'h08), {tag, " R5 ale"}, nand_ale, (wr && a == 5'h08));
        chk(nand_nce == m_cfg[11], {tag, " R4 nce level"}, nand_nce, m_cfg[11]);
        chk(nand_io_oe == wr, {tag, " R7 bus direction"}, nand_io_oe, wr);
        if (wr) chk(nand_io_out == d[7:0], {tag, " R6 io byte"}, nand_io_out, d[7:0]);
        chk(nand_nwe == !(k == 2 && wr), {tag, " R10 nwe timing"}, nand_nwe, !(k == 2 && wr));
        chk(nand_nre == !(k == 2 && !wr), {tag, " R10 nre timing"}, nand_nre, !(k == 2 && !wr));
        if (k == 2 && wr) sent_q.push_back(nand_io_out);
      end else begin
        chk(bus_ready, {tag, " R10 ready"}, bus_ready, 1);
        chk(pins_idle(), {tag, " R10 pins idle at ready"}, nand_nwe, 1);
        q = bus_rdata;
      end
    end
    bus_valid = 1'b0;
    @(negedge clk);
    chk(!bus_ready && pins_idle(), {tag, " R10 gap cycle"}, bus_ready, 0);
    // model updates
    if (wr && a == 5'h00) begin
      m_cfg = d[15:0] & 16'h8FFF;
      if (d[12]) ecc_q.delete();
    end
    if (is_pin && a == 5'h0C) ecc_q.push_back(wr ? d[7:0] : nand_io_in);
    busy = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input string tag);
    logic [31:0] q;
    acc(1'b1, a, d, q, tag);
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] q;
    acc(1'b0, a, 32'h0, q, tag);
    chk(q === exp, tag, q, exp);
  endtask

  task automatic chk_ecc(input string tag);
    logic [23:0] e = ecc_model();
    rd_exp(5'h14, {24'h0, e[7:0]},   {tag, " byte0"});
    rd_exp(5'h15, {24'h0, e[15:8]},  {tag, " byte1"});
    rd_exp(5'h16, {24'h0, e[23:16]}, {tag, " byte2"});
  endtask

  initial begin
    #1200000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_exp(5'h00, 32'h0, "R1 cfg after reset");
    rd_exp(5'h04, 32'h0, "R1 cmd after reset");
    rd_exp(5'h08, 32'h0, "R1 addr after reset");
    chk_ecc("R1 ecc after reset");

    // R11 undefined offsets
    rd_exp(5'h18, 32'h0, "R11 undefined read");
    rd_exp(5'h1C, 32'h0, "R11 undefined read 1c");
    wr_reg(5'h1C, 32'hFFFF_FFFF, "R11 undefined write");
    rd_exp(5'h00, 32'h0, "R11 cfg untouched");

    // R2 masking and clear bit
    wr_reg(5'h00, 32'hFFFF_FFFF, "R2 cfg all ones");
    rd_exp(5'h00, 32'h0000_8FFF, "R2 cfg readback");
    wr_reg(5'h00, 32'h0000_6AAA, "R2 cfg pattern");
    rd_exp(5'h00, 32'h0000_0AAA, "R2 cfg pattern readback");

    // R3 disabled
    wr_reg(5'h00, 32'h0000_0000, "R3 disable");
    wr_reg(5'h04, 32'h0000_1255, "R3 cmd write off");
    rd_exp(5'h04, 32'h0000_0055, "R3 cmd stored while off");
    wr_reg(5'h08, 32'h0000_00C3, "R3 addr write off");
    rd_exp(5'h08, 32'h0000_00C3, "R3 addr stored while off");
    nand_io_in = 8'h5A;
    rd_exp(5'h0C, 32'h0, "R3 data read off");
    wr_reg(5'h0C, 32'h0000_0077, "R3 data write off");
    chk(sent_q.size() == 0, "R3 no bytes sent", sent_q.size(), 0);
    chk_ecc("R3 ecc unchanged");

    // R4/R5 enabled, both chip-enable levels
    wr_reg(5'h00, 32'h0000_8000, "R4 enable ce low");
    wr_reg(5'h04, 32'h0000_0080, "R4 cmd 80");
    rd_exp(5'h04, 32'h0000_0080, "R4 cmd readback");
    wr_reg(5'h08, 32'h0000_0011, "R5 addr 11");
    rd_exp(5'h08, 32'h0000_0011, "R5 addr readback");
    wr_reg(5'h00, 32'h0000_8800, "R4 enable ce high");
    wr_reg(5'h04, 32'h0000_0030, "R4 cmd 30 ce high");
    wr_reg(5'h08, 32'h0000_00FE, "R5 addr fe ce high");
    chk(sent_q.size() == 4, "R4 latch cycles sent", sent_q.size(), 4);
    chk_ecc("R6 latch cycles skip ecc");

    // R6/R9 data writes
    wr_reg(5'h00, 32'h0000_9000, "R2 clear and enable");
    chk_ecc("R2 ecc cleared");
    foreach (ecc_q[i]) ;
    for (int i = 0; i < 12; i++) wr_reg(5'h0C, 32'h0000_0000 | ((i * 37 + 5) & 8'hFF), "R6 data write");
    chk_ecc("R9 ecc after writes");

    // R7 reads mixed in
    for (int i = 0; i < 6; i++) begin
      nand_io_in = 8'(i * 91 + 3);
      rd_exp(5'h0C, {24'h0, 8'(i * 91 + 3)}, "R7 data read");
    end
    chk_ecc("R9 ecc after mixed stream");

    // R8 status
    nand_rb = 1'b0;
    rd_exp(5'h10, 32'h0, "R8 busy");
    nand_rb = 1'b1;
    rd_exp(5'h10, 32'h1, "R8 ready");

    // R12 write protect
    wp_on = 1'b0;
    @(negedge clk);
    chk(nand_nwp == 1'b1, "R12 nwp released", nand_nwp, 1);
    wp_on = 1'b1;
    @(negedge clk);
    chk(nand_nwp == 1'b0, "R12 nwp active", nand_nwp, 0);

    // R13 wrap past 256 bytes
    wr_reg(5'h00, 32'h0000_9000, "R13 clear");
    for (int i = 0; i < 260; i++) wr_reg(5'h0C, 32'((i * 13 + 1) & 8'hFF), "R13 long stream");
    chk_ecc("R13 ecc after wrap");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule